// File: doc/BRIEF.md
# Clearable Chained Up Counter

This block is an up counter built from identical one-bit slices. Each slice holds one registered bit and computes two things from that bit and its incoming carry. The first is the next count bit. The second is a fast carry that feeds the slice above it. A two-way selector in each slice picks either the counted bit or a parallel load bit. A synchronous active-low clear then masks the selector output, so a low clear zeroes the bit whatever the selector chose.

The parent design sets the width with a parameter. The count enable drives the carry input of the lowest slice, so the whole counter steps only while the enable is high. The carry vector comes out bit by bit, and the carry out of the top slice serves as a terminal-count flag. The count is registered. The carry vector and the terminal-count flag are combinational in the current count and the enable.

Top module: `clearable_chain_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 0 at that edge.
- R2: With `rst` low, `clr_n` low at a rising edge makes `count` 0 after that edge, whatever `load` and `cnt_en` are.
- R3: With `clr_n` high and `load` high, `count` takes the value of `load_val` at the edge, whatever `cnt_en` is.
- R4: With `clr_n` high, `load` low and `cnt_en` high, `count` increases by one at the edge, modulo 2^W.
- R5: With `clr_n` high, `load` low and `cnt_en` low, `count` keeps its value.
- R6: Bit i of `carry` is 1 exactly when `cnt_en` is high and bits 0 through i of `count` are all 1.
- R7: `term_cnt` is 1 exactly when `cnt_en` is high and every bit of `count` is 1.
- R8: When `count` is all ones and the counter steps under R4, the next value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Synchronous clear, active low |
| load | input | 1 | Parallel load select |
| cnt_en | input | 1 | Count enable; carry input of slice 0 |
| load_val | input | W | Parallel load data |
| count | output | W | Registered count value |
| carry | output | W | Fast carry out of each slice |
| term_cnt | output | 1 | All ones while enabled |

## Verification
The interesting collisions come from clear, load and count reaching the same edge. Clear must beat load, and load must beat the increment. The random stimulus draws `clr_n`, `load` and `cnt_en` on their own in every cycle, so all eight combinations occur often. Directed steps add three cases: clear together with an all-ones load, load together with enable at terminal count, and a wrap. A reference model applies clear, then load, then count to produce the expected value after each edge. The same model produces the expected carry vector and terminal flag before each edge.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  parameter int unsigned CTR_W_DEFAULT = 8;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } ctr_act_e;

  function automatic ctr_act_e decode_act(input logic clr_n, input logic ld,
                                          input logic en);
    if (!clr_n)   return ACT_CLEAR;
    else if (ld)  return ACT_LOAD;
    else if (en)  return ACT_COUNT;
    else          return ACT_HOLD;
  endfunction
endpackage

// File: rtl/ctr_bit_cell.sv
module ctr_bit_cell (
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  input  logic ld,
  input  logic d,
  input  logic ci,
  output logic q,
  output logic co
);
  logic nxt_bit;
  logic sel_bit;

  // count function and fast-carry function kept apart
  assign nxt_bit = q ^ ci;
  assign co      = q & ci;
  assign sel_bit = ld ? d : nxt_bit;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= sel_bit & clr_n;
  end
endmodule

// File: rtl/ctr_carry_chain.sv
module ctr_carry_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         ld,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] co
);
  logic [W:0] ci_vec;

  assign ci_vec[0] = en;

  for (genvar i = 0; i < W; i++) begin : g_slice
    ctr_bit_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .clr_n (clr_n),
      .ld    (ld),
      .d     (d[i]),
      .ci    (ci_vec[i]),
      .q     (q[i]),
      .co    (co[i])
    );
    assign ci_vec[i+1] = co[i];
  end
endmodule

// File: rtl/clearable_chain_counter.sv
module clearable_chain_counter #(
  parameter int unsigned W = ctr_pkg::CTR_W_DEFAULT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         load,
  input  logic         cnt_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic [W-1:0] carry,
  output logic         term_cnt
);
  localparam int unsigned MSB = W - 1;

  ctr_carry_chain #(.W(W)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .clr_n (clr_n),
    .ld    (load),
    .en    (cnt_en),
    .d     (load_val),
    .q     (count),
    .co    (carry)
  );

  assign term_cnt = carry[MSB];
endmodule

// File: rtl/clearable_chain_counter_chk.sv
module clearable_chain_counter_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         clr_n,
  input logic         load,
  input logic         cnt_en,
  input logic [W-1:0] load_val,
  input logic [W-1:0] count,
  input logic [W-1:0] carry,
  input logic         term_cnt
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  assert_reset_zero_R1: assert property (@(posedge clk)
    past_ok && $past(rst) |-> count == '0);

  assert_clear_wins_R2: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> count == '0);

  assert_load_value_R3: assert property (@(posedge clk) disable iff (rst)
    clr_n && load |=> count == $past(load_val));

  assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
    clr_n && !load && cnt_en |=> count == W'($past(count) + 1'b1));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    clr_n && !load && !cnt_en |=> $stable(count));

  assert_carry_low_R6: assert property (@(posedge clk) disable iff (rst)
    carry[0] == (cnt_en & count[0]));

  assert_term_flag_R7: assert property (@(posedge clk) disable iff (rst)
    term_cnt == (cnt_en && (&count)));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    clr_n && !load && term_cnt |=> count == '0);
endmodule

bind clearable_chain_counter clearable_chain_counter_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr_n    (clr_n),
  .load     (load),
  .cnt_en   (cnt_en),
  .load_val (load_val),
  .count    (count),
  .carry    (carry),
  .term_cnt (term_cnt)
);

// File: tb/clearable_chain_counter_bench.sv
module clearable_chain_counter_bench;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr_n = 1'b1;
  logic         load = 1'b0;
  logic         cnt_en = 1'b0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] count;
  logic [W-1:0] carry;
  logic         term_cnt;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic        done = 1'b0;
  logic [W-1:0] exp_cnt = '0;

  always #2.5 clk = ~clk;

  clearable_chain_counter #(.W(W)) u_clearable_chain_counter (
    .clk(clk), .rst(rst), .clr_n(clr_n), .load(load), .cnt_en(cnt_en),
    .load_val(load_val), .count(count), .carry(carry), .term_cnt(term_cnt)
  );

  function automatic logic [W-1:0] model_next(input logic r, input logic c,
      input logic l, input logic e, input logic [W-1:0] v, input logic [W-1:0] cur);
    if (r)       return '0;
    else if (!c) return '0;
    else if (l)  return v;
    else if (e)  return cur + 1'b1;
    else         return cur;
  endfunction

  function automatic logic [W-1:0] model_carry(input logic e, input logic [W-1:0] cur);
    logic [W-1:0] res;
    logic run;
    run = e;
    for (int i = 0; i < W; i++) begin
      run = run & cur[i];
      res[i] = run;
    end
    return res;
  endfunction

  function automatic string req_of(input logic r, input logic c, input logic l,
      input logic e, input logic [W-1:0] cur);
    if (r)       return "R1";
    else if (!c) return "R2";
    else if (l)  return "R3";
    else if (e)  return (&cur) ? "R8" : "R4";
    else         return "R5";
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic c, input logic l,
                      input logic e, input logic [W-1:0] v);
    string rq;
    @(negedge clk);
    rst = r; clr_n = c; load = l; cnt_en = e; load_val = v;
    #0.5;
    if (!r) begin
      check("R6", carry, model_carry(e, exp_cnt));
      check("R7", W'(term_cnt), W'(e && (&exp_cnt)));
    end
    rq = req_of(r, c, l, e, exp_cnt);
    exp_cnt = model_next(r, c, l, e, v, exp_cnt);
    @(posedge clk);
    #1;
    check(rq, count, exp_cnt);
  endtask

  initial begin
    void'($urandom(32'd20251));
    step(1, 1, 0, 0, '0);
    step(1, 1, 1, 1, 8'h5a);              // R1 reset beats load
    step(0, 1, 0, 0, '0);                 // R5 hold after reset
    step(0, 1, 1, 0, 8'hfd);              // R3 load without enable
    step(0, 1, 0, 1, '0);                 // R4
    step(0, 1, 0, 1, '0);                 // R4 to all ones
    step(0, 1, 0, 1, '0);                 // R8 wrap, R7 flag high
    step(0, 1, 1, 1, 8'hff);              // R3 load with enable
    step(0, 1, 1, 1, 8'h12);              // R3 load beats count at terminal
    step(0, 0, 1, 1, 8'hff);              // R2 clear beats load
    step(0, 1, 1, 0, 8'h80);
    step(0, 0, 0, 0, '0);                 // R2 clear alone
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] rr;
      rr = 4'($urandom());
      step(rr == 4'd0 && k % 7 == 0, ($urandom() % 8) != 0, ($urandom() % 5) == 0,
           ($urandom() % 4) != 0, W'($urandom()));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule